// File: doc/BRIEF.md
# Measurement Window Limiter and Level Indicator

This block watches one 10-bit measurement picked from six candidate signals by a 4-bit source code. Only the upper 8 bits of the measurement are used in comparisons. The block has two functions, and both use the same four 8-bit configuration bytes, `lim_p0` to `lim_p3`.

In limiter mode, `lim_p0` is the low trigger and `lim_p1` is the value substituted below it. `lim_p2` is the high trigger and `lim_p3` is the value substituted above it. When the measurement leaves the window, the block raises an override flag and gives a 10-bit replacement value for the output path.

In indicator mode, `lim_p0`, `lim_p1` and `lim_p2` are three ascending thresholds. The block drives a 2-bit code onto two I/O pins, with its output enable raised, to show which band the measurement falls in. When indicator mode is off, the pins are released.

The configuration inputs are treated as static. A new result is taken on each clock edge where `meas_stb` is high, and the registered outputs hold between strobes.

Top module: `lvl_guard`

## Requirements
- R1: After an asynchronous reset, `ovr_valid`, `ovr_value`, `pin_code` and `pin_oe` are all zero.
- R2: The outputs take a new value only at a rising clock edge where `meas_stb` is 1. That value appears from the same edge. Without the strobe, all outputs hold their value.
- R3: `src_sel` picks the measurement as follows:
  - 4'b0000 selects `sig_gof`.
  - 4'b0010 selects `sig_temp`.
  - 4'b0011 selects `sig_vout`.
  - 4'b0100 selects `sig_io1`.
  - 4'b0101 selects `sig_io2`.
  - 4'b0110 selects `sig_amp`.
  
  Only bits [9:2] of the selected signal, called M, are compared.
- R4: With the limiter active and M < `lim_p0`, the block sets `ovr_valid`=1 and `ovr_value`={`lim_p1`,2'b00}. M equal to `lim_p0` raises nothing. If both triggers are met, the low one is served.
- R5: With the limiter active and M > `lim_p2`, the block sets `ovr_valid`=1 and `ovr_value`={`lim_p3`,2'b00}. M equal to `lim_p2` raises nothing. With no override, `ovr_value` is 0.
- R6: With `steer_en`=1, `pin_oe` is 1. `pin_code` is 3 if M>=`lim_p2`, otherwise 2 if M>=`lim_p1`, otherwise 1 if M>=`lim_p0`, and otherwise 0.
- R7: Indicator mode accepts only the source codes 0000, 0010, 0011 and 0110. With the codes 0100 or 0101 selected, `pin_code` is 0 and `pin_oe` stays 1.
- R8: When `steer_en`=1, the limiter is inactive even if `alarm_en`=1.
- R9: When `vout_en`=1 and `cout_en`=1, the limiter is inactive.
- R10: A source code outside the six listed in R3 leaves the limiter inactive and sets `pin_code` to 0.
- R11: With `steer_en`=0, `pin_oe` is 0 and `pin_code` is 0.
- R12: With `alarm_en`=0, `ovr_valid` is 0 and `ovr_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_stb | input | 1 | Take a new result at this edge |
| sig_temp | input | 10 | Temperature measurement |
| sig_amp | input | 10 | Input amplifier measurement |
| sig_gof | input | 10 | Gain/offset stage measurement |
| sig_vout | input | 10 | Voltage output measurement |
| sig_io1 | input | 10 | First I/O pin measurement |
| sig_io2 | input | 10 | Second I/O pin measurement |
| src_sel | input | 4 | Source select code |
| alarm_en | input | 1 | Limiter mode enable |
| steer_en | input | 1 | Indicator mode enable |
| vout_en | input | 1 | Voltage output enabled |
| cout_en | input | 1 | Current output enabled |
| lim_p0 | input | 8 | Low trigger / first threshold |
| lim_p1 | input | 8 | Low substitute / second threshold |
| lim_p2 | input | 8 | High trigger / third threshold |
| lim_p3 | input | 8 | High substitute |
| ovr_valid | output | 1 | Override active |
| ovr_value | output | 10 | Override value |
| pin_code | output | 2 | Code for the two I/O pins, bit 1 drives the second pin and bit 0 the first |
| pin_oe | output | 1 | I/O pin output enable |

## Verification
The properties assume that the mode and source inputs sampled at a strobe edge are the ones that shaped the result, and that the configuration stays fixed between strobes. The bench therefore changes inputs only on falling edges and only while the strobe is low, or together with a single strobe pulse. The band-ordering check assumes ascending thresholds (`lim_p0` < `lim_p1` < `lim_p2`), so every indicator test programs them in that order. Boundary values sit exactly on each trigger and threshold, with nonzero low bits to show that those bits are ignored.

// File: rtl/lvl_guard_pkg.sv
package lvl_guard_pkg;
  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] SRC_GOF  = 4'b0000;
  localparam logic [SEL_W-1:0] SRC_TEMP = 4'b0010;
  localparam logic [SEL_W-1:0] SRC_VOUT = 4'b0011;
  localparam logic [SEL_W-1:0] SRC_IO1  = 4'b0100;
  localparam logic [SEL_W-1:0] SRC_IO2  = 4'b0101;
  localparam logic [SEL_W-1:0] SRC_AMP  = 4'b0110;

  // Codes legal for the window limiter: all six sources
  function automatic logic src_limit_ok(input logic [SEL_W-1:0] code);
    case (code)
      SRC_GOF, SRC_TEMP, SRC_VOUT, SRC_IO1, SRC_IO2, SRC_AMP: src_limit_ok = 1'b1;
      default: src_limit_ok = 1'b0;
    endcase
  endfunction

  // Codes legal for the level indicator: internal analog points only
  function automatic logic src_steer_ok(input logic [SEL_W-1:0] code);
    case (code)
      SRC_GOF, SRC_TEMP, SRC_VOUT, SRC_AMP: src_steer_ok = 1'b1;
      default: src_steer_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lvl_guard_srcsel.sv
module lvl_guard_srcsel
  import lvl_guard_pkg::*;
#(
  parameter int SIG_W = 10
) (
  input  logic [SIG_W-1:0] sig_temp,
  input  logic [SIG_W-1:0] sig_amp,
  input  logic [SIG_W-1:0] sig_gof,
  input  logic [SIG_W-1:0] sig_vout,
  input  logic [SIG_W-1:0] sig_io1,
  input  logic [SIG_W-1:0] sig_io2,
  input  logic [SEL_W-1:0] src_sel,
  output logic [SIG_W-1:0] meas,
  output logic             limit_ok,
  output logic             steer_ok
);
  always_comb begin
    case (src_sel)
      SRC_GOF:  meas = sig_gof;
      SRC_TEMP: meas = sig_temp;
      SRC_VOUT: meas = sig_vout;
      SRC_IO1:  meas = sig_io1;
      SRC_IO2:  meas = sig_io2;
      SRC_AMP:  meas = sig_amp;
      default:  meas = '0;
    endcase
  end

  assign limit_ok = src_limit_ok(src_sel);
  assign steer_ok = src_steer_ok(src_sel);
endmodule

// File: rtl/lvl_guard_window.sv
module lvl_guard_window #(
  parameter int CMP_W = 8
) (
  input  logic             active,
  input  logic [CMP_W-1:0] meas_hi,
  input  logic [CMP_W-1:0] lo_trig,
  input  logic [CMP_W-1:0] lo_level,
  input  logic [CMP_W-1:0] hi_trig,
  input  logic [CMP_W-1:0] hi_level,
  output logic             hit,
  output logic [CMP_W-1:0] level
);
  logic below;
  logic above;

  assign below = meas_hi < lo_trig;
  assign above = meas_hi > hi_trig;

  // Low side is served first when a misconfigured window overlaps
  always_comb begin
    hit   = 1'b0;
    level = '0;
    if (active && below) begin
      hit   = 1'b1;
      level = lo_level;
    end else if (active && above) begin
      hit   = 1'b1;
      level = hi_level;
    end
  end
endmodule

// File: rtl/lvl_guard_steer.sv
module lvl_guard_steer #(
  parameter int CMP_W     = 8,
  parameter int NUM_STEPS = 3,
  localparam int CODE_W   = $clog2(NUM_STEPS + 1)
) (
  input  logic                            active,
  input  logic [CMP_W-1:0]                meas_hi,
  input  logic [NUM_STEPS-1:0][CMP_W-1:0] thr,
  output logic [CODE_W-1:0]               code
);
  logic [NUM_STEPS-1:0] reached;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_cmp
    assign reached[g] = meas_hi >= thr[g];
  end

  // Highest threshold reached sets the band number
  always_comb begin
    code = '0;
    if (active) begin
      for (int i = 0; i < NUM_STEPS; i++) begin
        if (reached[i]) code = CODE_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/lvl_guard.sv
module lvl_guard
  import lvl_guard_pkg::*;
#(
  parameter int SIG_W = 10,
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_stb,
  input  logic [SIG_W-1:0] sig_temp,
  input  logic [SIG_W-1:0] sig_amp,
  input  logic [SIG_W-1:0] sig_gof,
  input  logic [SIG_W-1:0] sig_vout,
  input  logic [SIG_W-1:0] sig_io1,
  input  logic [SIG_W-1:0] sig_io2,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             alarm_en,
  input  logic             steer_en,
  input  logic             vout_en,
  input  logic             cout_en,
  input  logic [CMP_W-1:0] lim_p0,
  input  logic [CMP_W-1:0] lim_p1,
  input  logic [CMP_W-1:0] lim_p2,
  input  logic [CMP_W-1:0] lim_p3,
  output logic             ovr_valid,
  output logic [SIG_W-1:0] ovr_value,
  output logic [1:0]       pin_code,
  output logic             pin_oe
);
  localparam int LSB_DROP  = SIG_W - CMP_W;
  localparam int NUM_STEPS = 3;
  localparam int CODE_W    = $clog2(NUM_STEPS + 1);

  logic [SIG_W-1:0] meas;
  logic             limit_ok;
  logic             steer_ok;
  logic [CMP_W-1:0] meas_hi;
  logic             lsb_unused;

  lvl_guard_srcsel #(.SIG_W(SIG_W)) u_src (
    .sig_temp (sig_temp),
    .sig_amp  (sig_amp),
    .sig_gof  (sig_gof),
    .sig_vout (sig_vout),
    .sig_io1  (sig_io1),
    .sig_io2  (sig_io2),
    .src_sel  (src_sel),
    .meas     (meas),
    .limit_ok (limit_ok),
    .steer_ok (steer_ok)
  );

  assign meas_hi    = meas[SIG_W-1:LSB_DROP];
  assign lsb_unused = ^meas[LSB_DROP-1:0];

  // Indicator mode dominates; dual analog outputs also mute the limiter
  logic limit_act;
  logic steer_act;
  assign steer_act = steer_en && steer_ok;
  assign limit_act = alarm_en && !steer_en && !(vout_en && cout_en) && limit_ok;

  logic             win_hit;
  logic [CMP_W-1:0] win_level;

  lvl_guard_window #(.CMP_W(CMP_W)) u_win (
    .active   (limit_act),
    .meas_hi  (meas_hi),
    .lo_trig  (lim_p0),
    .lo_level (lim_p1),
    .hi_trig  (lim_p2),
    .hi_level (lim_p3),
    .hit      (win_hit),
    .level    (win_level)
  );

  logic [NUM_STEPS-1:0][CMP_W-1:0] thr;
  logic [CODE_W-1:0]               band;
  assign thr = {lim_p2, lim_p1, lim_p0};

  lvl_guard_steer #(.CMP_W(CMP_W), .NUM_STEPS(NUM_STEPS)) u_steer (
    .active  (steer_act),
    .meas_hi (meas_hi),
    .thr     (thr),
    .code    (band)
  );

  // Next-state
  logic             ovr_valid_d;
  logic [SIG_W-1:0] ovr_value_d;
  logic [1:0]       pin_code_d;
  logic             pin_oe_d;

  always_comb begin
    ovr_valid_d = ovr_valid;
    ovr_value_d = ovr_value;
    pin_code_d  = pin_code;
    pin_oe_d    = pin_oe;
    if (meas_stb) begin
      ovr_valid_d = win_hit;
      ovr_value_d = {win_level, {LSB_DROP{1'b0}}};
      pin_code_d  = band;
      pin_oe_d    = steer_en;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_valid <= 1'b0;
      ovr_value <= '0;
      pin_code  <= '0;
      pin_oe    <= 1'b0;
    end else begin
      ovr_valid <= ovr_valid_d;
      ovr_value <= ovr_value_d;
      pin_code  <= pin_code_d;
      pin_oe    <= pin_oe_d;
    end
  end
endmodule

// File: rtl/lvl_guard_chk.sv
module lvl_guard_chk #(
  parameter int SIG_W = 10,
  parameter int CMP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_stb,
  input logic [3:0]       src_sel,
  input logic             alarm_en,
  input logic             steer_en,
  input logic             vout_en,
  input logic             cout_en,
  input logic             ovr_valid,
  input logic [SIG_W-1:0] ovr_value,
  input logic [1:0]       pin_code,
  input logic             pin_oe
);
  localparam int LSB_DROP = SIG_W - CMP_W;

  logic sel_reserved;
  assign sel_reserved = !(src_sel inside {4'b0000, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0110});

  // R2
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_stb |=> ($stable(ovr_valid) && $stable(ovr_value) && $stable(pin_code) && $stable(pin_oe)));

  // R4
  level_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_valid |-> (ovr_value[LSB_DROP-1:0] == '0));

  // R5
  idle_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_valid |-> (ovr_value == '0));

  // R8
  steer_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && steer_en) |=> (pin_oe && !ovr_valid));

  // R9
  dual_out_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && vout_en && cout_en) |=> !ovr_valid);

  // R10
  reserved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && sel_reserved) |=> (!ovr_valid && pin_code == 2'b00));

  // R11
  released_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> (pin_code == 2'b00));

  // R12
  limiter_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && !alarm_en) |=> !ovr_valid);
endmodule

bind lvl_guard lvl_guard_chk #(.SIG_W(SIG_W), .CMP_W(CMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .meas_stb  (meas_stb),
  .src_sel   (src_sel),
  .alarm_en  (alarm_en),
  .steer_en  (steer_en),
  .vout_en   (vout_en),
  .cout_en   (cout_en),
  .ovr_valid (ovr_valid),
  .ovr_value (ovr_value),
  .pin_code  (pin_code),
  .pin_oe    (pin_oe)
);

// File: tb/sim_lvl_guard.sv
`timescale 1ns/100ps
module sim_lvl_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       meas_stb = 1'b0;
  logic [9:0] sig_temp = '0, sig_amp = '0, sig_gof = '0;
  logic [9:0] sig_vout = '0, sig_io1 = '0, sig_io2 = '0;
  logic [3:0] src_sel = '0;
  logic       alarm_en = 1'b0, steer_en = 1'b0, vout_en = 1'b0, cout_en = 1'b0;
  logic [7:0] lim_p0 = '0, lim_p1 = '0, lim_p2 = '0, lim_p3 = '0;
  logic       ovr_valid;
  logic [9:0] ovr_value;
  logic [1:0] pin_code;
  logic       pin_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lvl_guard u0 (
    .clk(clk), .rst_n(rst_n), .meas_stb(meas_stb),
    .sig_temp(sig_temp), .sig_amp(sig_amp), .sig_gof(sig_gof),
    .sig_vout(sig_vout), .sig_io1(sig_io1), .sig_io2(sig_io2),
    .src_sel(src_sel), .alarm_en(alarm_en), .steer_en(steer_en),
    .vout_en(vout_en), .cout_en(cout_en),
    .lim_p0(lim_p0), .lim_p1(lim_p1), .lim_p2(lim_p2), .lim_p3(lim_p3),
    .ovr_valid(ovr_valid), .ovr_value(ovr_value),
    .pin_code(pin_code), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Strobe once, sample on the falling edge after the capturing edge
  task automatic strobe();
    @(negedge clk) meas_stb = 1'b1;
    @(negedge clk) meas_stb = 1'b0;
  endtask

  task automatic chk_ovr(input string tag, input logic v, input logic [9:0] val);
    chk({tag, " ovr_valid"}, 16'(ovr_valid), 16'(v));
    chk({tag, " ovr_value"}, 16'(ovr_value), 16'(val));
  endtask

  task automatic set_window();
    lim_p0 = 8'h40; lim_p1 = 8'h11; lim_p2 = 8'hC0; lim_p3 = 8'hEE;
  endtask

  task automatic t_reset();
    chk("R1 ovr_valid", 16'(ovr_valid), 16'h0);
    chk("R1 ovr_value", 16'(ovr_value), 16'h0);
    chk("R1 pin_code", 16'(pin_code), 16'h0);
    chk("R1 pin_oe", 16'(pin_oe), 16'h0);
  endtask

  task automatic t_sources();
    set_window(); alarm_en = 1'b1; steer_en = 1'b0;
    sig_temp = 10'h3FF; sig_amp = 10'h004; sig_gof = 10'h200;
    sig_vout = 10'h3FC; sig_io1 = 10'h000; sig_io2 = 10'h300;
    src_sel = 4'b0010; strobe(); chk_ovr("R3 temp", 1'b1, 10'h3B8);
    src_sel = 4'b0110; strobe(); chk_ovr("R3 amp", 1'b1, 10'h044);
    src_sel = 4'b0000; strobe(); chk_ovr("R3 gof", 1'b0, 10'h000);
    src_sel = 4'b0011; strobe(); chk_ovr("R3 vout", 1'b1, 10'h3B8);
    src_sel = 4'b0100; strobe(); chk_ovr("R3 io1", 1'b1, 10'h044);
    src_sel = 4'b0101; strobe(); chk_ovr("R3 io2", 1'b0, 10'h000);
  endtask

  task automatic t_bounds();
    set_window(); alarm_en = 1'b1; src_sel = 4'b0000;
    sig_gof = 10'h103; strobe(); chk_ovr("R4 equal low", 1'b0, 10'h000);
    sig_gof = 10'h0FF; strobe(); chk_ovr("R4 below low", 1'b1, 10'h044);
    sig_gof = 10'h303; strobe(); chk_ovr("R5 equal high", 1'b0, 10'h000);
    sig_gof = 10'h304; strobe(); chk_ovr("R5 above high", 1'b1, 10'h3B8);
    // overlapping window: low side served
    lim_p0 = 8'h90; lim_p2 = 8'h10; sig_gof = 10'h200;
    strobe(); chk_ovr("R4 overlap", 1'b1, 10'h044);
    set_window();
  endtask

  task automatic t_hold();
    set_window(); alarm_en = 1'b1; src_sel = 4'b0000;
    sig_gof = 10'h000; strobe();
    @(negedge clk) sig_gof = 10'h200;
    repeat (3) @(negedge clk);
    chk_ovr("R2 hold", 1'b1, 10'h044);
    strobe(); chk_ovr("R2 update", 1'b0, 10'h000);
  endtask

  task automatic t_steer();
    logic [7:0] m [7];
    logic [1:0] e [7];
    m = '{8'h3F, 8'h40, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};
    e = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
    alarm_en = 1'b0; steer_en = 1'b1; src_sel = 4'b0000;
    lim_p0 = 8'h40; lim_p1 = 8'h80; lim_p2 = 8'hC0;
    for (int i = 0; i < 7; i++) begin
      sig_gof = {m[i], 2'b01}; strobe();
      chk($sformatf("R6 band m=%0h", m[i]), 16'(pin_code), 16'(e[i]));
      chk("R6 pin_oe", 16'(pin_oe), 16'h1);
    end
  endtask

  task automatic t_steer_src();
    steer_en = 1'b1; alarm_en = 1'b0;
    lim_p0 = 8'h40; lim_p1 = 8'h80; lim_p2 = 8'hC0;
    sig_io1 = 10'h3FF; sig_io2 = 10'h3FF; sig_amp = 10'h3FF;
    src_sel = 4'b0100; strobe(); chk("R7 io1 code", 16'(pin_code), 16'h0);
    chk("R7 io1 oe", 16'(pin_oe), 16'h1);
    src_sel = 4'b0101; strobe(); chk("R7 io2 code", 16'(pin_code), 16'h0);
    src_sel = 4'b0110; strobe(); chk("R7 amp code", 16'(pin_code), 16'h3);
  endtask

  task automatic t_prec();
    set_window(); alarm_en = 1'b1; steer_en = 1'b1; src_sel = 4'b0000;
    sig_gof = 10'h000; strobe();
    chk_ovr("R8 steer wins", 1'b0, 10'h000);
    chk("R8 pin_oe", 16'(pin_oe), 16'h1);
  endtask

  task automatic t_dual();
    set_window(); alarm_en = 1'b1; steer_en = 1'b0; src_sel = 4'b0000;
    sig_gof = 10'h000; vout_en = 1'b1; cout_en = 1'b1;
    strobe(); chk_ovr("R9 both outputs", 1'b0, 10'h000);
    cout_en = 1'b0; strobe(); chk_ovr("R9 one output", 1'b1, 10'h044);
    vout_en = 1'b0;
  endtask

  task automatic t_reserved();
    logic [3:0] codes [3];
    codes = '{4'b0001, 4'b0111, 4'b1111};
    set_window(); alarm_en = 1'b1; steer_en = 1'b0;
    sig_temp = '0; sig_amp = '0; sig_gof = '0; sig_vout = '0; sig_io1 = '0; sig_io2 = '0;
    for (int i = 0; i < 3; i++) begin
      src_sel = codes[i]; strobe();
      chk_ovr($sformatf("R10 code %b", codes[i]), 1'b0, 10'h000);
    end
    alarm_en = 1'b0; steer_en = 1'b1; lim_p0 = 8'h00; lim_p1 = 8'h00; lim_p2 = 8'h00;
    src_sel = 4'b1000; strobe(); chk("R10 steer code", 16'(pin_code), 16'h0);
    set_window();
  endtask

  task automatic t_steer_off();
    steer_en = 1'b0; alarm_en = 1'b0; src_sel = 4'b0000; sig_gof = 10'h3FF;
    lim_p0 = 8'h40; lim_p1 = 8'h80; lim_p2 = 8'hC0;
    strobe();
    chk("R11 pin_oe", 16'(pin_oe), 16'h0);
    chk("R11 pin_code", 16'(pin_code), 16'h0);
  endtask

  task automatic t_alarm_off();
    set_window(); alarm_en = 1'b0; steer_en = 1'b0; src_sel = 4'b0000;
    sig_gof = 10'h000; strobe();
    chk_ovr("R12 limiter off", 1'b0, 10'h000);
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sources();
    t_bounds();
    t_hold();
    t_steer();
    t_steer_src();
    t_prec();
    t_dual();
    t_reserved();
    t_steer_off();
    t_alarm_off();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule